// File: doc/BRIEF.md
# Buck Converter Startup Mode Sequencer

This block is the clocked controller that sits in front of the switch-control logic of a synchronous step-down converter. It chooses the phase the converter runs in: idle, monotonic start, forced PWM or skip. It tells the switch logic when switching may begin, steps the low-side sink current limit up after switching starts, and requests short low-side pulses that recharge the bootstrap capacitor.

A decoded three-level mode select picks the behaviour. The low level gives forced PWM straight away. The mid level, and an open pin, give forced PWM with a monotonic start into a pre-charged output. The high level gives skip mode, also with a monotonic start. During a monotonic start both switches stay off until the feedback voltage crosses the soft-start voltage. The block hands over to the steady mode only after the feedback-good flag has been held for a long, fixed window. Once the converter is in a steady mode, the mode select can move it between forced PWM and skip at any time. Dropping the enable, losing the supply-good flag or a thermal fault sends the block back to idle and clears all of its internal progress.

Top module: `buck_start_seq`

## Requirements
- R1: While `en_i` is low, `vdd_ok_i` is low or `hot_i` is high at a clock edge, or during reset, the block returns after that edge to phase IDLE (`phase_o` = 0), with `sw_en_o` = 0, `sink_lim_o` = 0 and `bst_refresh_o` = 0.
- R2: `mode_sel_i` is encoded as 2'b00 low, 2'b01 mid, 2'b10 high, and 2'b11 (open) is treated as mid. If the block is active and in IDLE with mode low, the next edge moves it to phase FPWM (`phase_o` = 2) with `sw_en_o` = 1.
- R3: If the block is active and in IDLE with any other mode, the next edge moves it to phase MONO (`phase_o` = 1) with `sw_en_o` = 0. `sw_en_o` stays 0 until an edge samples `fb_cross_ss_i` high, and it is 1 after that edge.
- R4: `bst_refresh_o` is high for exactly the one cycle in which `sw_en_o` first becomes 1, so the low side turns on first.
- R5: `sink_lim_o` is 0 when switching starts. It rises by one every 32 clock edges after that, reaches 3 after 96 edges and holds at 3.
- R6: In MONO with switching enabled, the block hands over on the 4096th consecutive edge at which `fb_good_i` is sampled high. Any edge at which it is sampled low restarts the count.
- R7: The handover goes to SKIP (`phase_o` = 3) if `mode_sel_i` is high at the handover edge, and to FPWM otherwise. A change of mode during MONO leaves the phase at MONO.
- R8: In FPWM or SKIP, the edge after `mode_sel_i` changes puts the block in SKIP if the mode is high, and in FPWM for any other mode.
- R9: In SKIP, when `hs_on_i` is sampled low on 9 consecutive edges, `bst_refresh_o` pulses for one cycle and the idle count starts again. A high `hs_on_i` resets the count.
- R10: Apart from the start pulse of R4, `bst_refresh_o` stays low in FPWM and MONO, whatever `hs_on_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable |
| vdd_ok_i | input | 1 | Internal supply above lockout threshold |
| hot_i | input | 1 | Thermal shutdown flag |
| mode_sel_i | input | 2 | Decoded mode select (00 low, 01 mid, 10 high, 11 open) |
| fb_cross_ss_i | input | 1 | Feedback has crossed the soft-start voltage |
| fb_good_i | input | 1 | Feedback above the power-good fraction of reference |
| hs_on_i | input | 1 | High-side switch is conducting this cycle |
| phase_o | output | 2 | Phase: 0 IDLE, 1 MONO, 2 FPWM, 3 SKIP |
| sw_en_o | output | 1 | Switching permitted |
| sink_lim_o | output | LIM_W | Low-side sink current limit step code |
| bst_refresh_o | output | 1 | Low-side pulse request for bootstrap charge |

## Verification
A good-window counter that starts in the wrong state, or that is not cleared when the feedback-good flag drops, shows up as a handover on the wrong cycle. The bench checks `phase_o` one edge before and one edge at the expected handover, so an offset of a single cycle is caught. A ramp step counter that is off by one moves the `sink_lim_o` change by one cycle at the 32-edge boundary. A skip idle counter that is wrong shifts the `bst_refresh_o` pulse away from the ninth idle edge, or makes it appear in FPWM. An inactive condition that leaves state behind shows up on the very next edge, as a non-zero `phase_o`, `sw_en_o` or `sink_lim_o`.

// File: rtl/bss_pkg.sv
// Shared types for the buck startup sequencer.
// Assumes a two-bit phase encoding that the switch-control logic decodes directly.
package bss_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MONO = 2'd1,
        PH_FPWM = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_MID  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_OPEN = 2'd3
    } msel_t;
endpackage

// File: rtl/bss_phase_fsm.sv
// Phase state machine: picks the start style from the mode, holds switching off
// until feedback crosses soft-start, and times the good window before handover.
// Assumes all inputs are already synchronous to clk.
module bss_phase_fsm
    import bss_pkg::*;
#(
    parameter int GOOD_WAIT = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic [1:0] mode_i,
    input  logic       cross_i,
    input  logic       good_i,
    output phase_t     phase_o,
    output logic       sw_on_o,
    output logic       start_o
);
    localparam int GW_W = (GOOD_WAIT > 1) ? $clog2(GOOD_WAIT) : 1;
    localparam logic [GW_W-1:0] GW_LAST = GW_W'(GOOD_WAIT - 1);

    phase_t          state;
    logic            sw_on;
    logic            start_q;
    logic [GW_W-1:0] good_cnt;
    phase_t          steady_pick;

    // Steady-mode target chosen from the present mode select
    always_comb steady_pick = (mode_i == SEL_HIGH) ? PH_SKIP : PH_FPWM;

    // Phase transitions, switching permission and good-window counting
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            state    <= PH_IDLE;
            sw_on    <= 1'b0;
            start_q  <= 1'b0;
            good_cnt <= '0;
        end else begin
            start_q <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (mode_i == SEL_LOW) begin
                        state   <= PH_FPWM;
                        sw_on   <= 1'b1;
                        start_q <= 1'b1;
                    end else begin
                        state <= PH_MONO;
                    end
                end
                PH_MONO: begin
                    if (!sw_on) begin
                        if (cross_i) begin
                            sw_on   <= 1'b1;
                            start_q <= 1'b1;
                        end
                    end else if (!good_i) begin
                        good_cnt <= '0;
                    end else if (good_cnt == GW_LAST) begin
                        good_cnt <= '0;
                        state    <= steady_pick;
                    end else begin
                        good_cnt <= good_cnt + 1'b1;
                    end
                end
                default: state <= steady_pick;
            endcase
        end
    end

    assign phase_o = state;
    assign sw_on_o = sw_on;
    assign start_o = start_q;

    AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (state == PH_IDLE && !sw_on)); // R1
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_MONO && !sw_on && !cross_i) |=> !sw_on); // R3
    AST_NO_EARLY_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_MONO && !good_i) |=> (state == PH_MONO || state == PH_IDLE)); // R6
    AST_STEADY_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && (state == PH_FPWM || state == PH_SKIP) && mode_i == SEL_HIGH)
        |=> state == PH_SKIP); // R8
endmodule

// File: rtl/bss_sink_ramp.sv
// Sink current limit ramp: steps the code up once every STEP_CYC edges while
// switching is allowed and saturates at the top code.
// Assumes sw_on_i rises exactly when switching starts.
module bss_sink_ramp #(
    parameter int STEP_CYC = 32,
    parameter int LIM_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             sw_on_i,
    output logic [LIM_W-1:0] lim_o
);
    localparam int ST_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [ST_W-1:0]  ST_LAST = ST_W'(STEP_CYC - 1);
    localparam logic [LIM_W-1:0] LIM_TOP = {LIM_W{1'b1}};

    logic [ST_W-1:0]  step_cnt;
    logic [LIM_W-1:0] lim_q;

    // Step timer and saturating limit code
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i || !sw_on_i) begin
            step_cnt <= '0;
            lim_q    <= '0;
        end else if (lim_q != LIM_TOP) begin
            if (step_cnt == ST_LAST) begin
                step_cnt <= '0;
                lim_q    <= lim_q + 1'b1;
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

    assign lim_o = lim_q;

    AST_LIM_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && sw_on_i) |=>
        (lim_q == $past(lim_q) || lim_q == $past(lim_q) + 1'b1)); // R5
    AST_LIM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> lim_q == '0); // R1
endmodule

// File: rtl/bss_bst_refresh.sv
// Bootstrap refresh timer: in skip, counts edges with the high side idle and
// requests a one-cycle low-side pulse once the idle run passes IDLE_MAX.
// Assumes hs_on_i reflects the high-side gate of the current cycle.
module bss_bst_refresh #(
    parameter int IDLE_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic skip_i,
    input  logic hs_on_i,
    output logic pulse_o
);
    localparam int ID_W = $clog2(IDLE_MAX + 1);
    localparam logic [ID_W-1:0] ID_TOP = ID_W'(IDLE_MAX);

    logic [ID_W-1:0] idle_cnt;
    logic            pulse_q;

    // Idle run counter and refresh pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i || !skip_i || hs_on_i) begin
            idle_cnt <= '0;
            pulse_q  <= 1'b0;
        end else if (idle_cnt == ID_TOP) begin
            idle_cnt <= '0;
            pulse_q  <= 1'b1;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
            pulse_q  <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;

    AST_REFRESH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R9
    AST_NO_REFRESH_OUTSIDE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        !skip_i |=> !pulse_q); // R10
endmodule

// File: rtl/buck_start_seq.sv
// Top of the buck startup sequencer. It ties together the phase machine, the
// sink limit ramp and the bootstrap refresh timer.
// Assumes synchronous, already-decoded inputs and a synchronous active-low reset.
module buck_start_seq
    import bss_pkg::*;
#(
    parameter int GOOD_WAIT    = 4096,
    parameter int RAMP_STEP    = 32,
    parameter int LIM_W        = 2,
    parameter int REFRESH_IDLE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             vdd_ok_i,
    input  logic             hot_i,
    input  logic [1:0]       mode_sel_i,
    input  logic             fb_cross_ss_i,
    input  logic             fb_good_i,
    input  logic             hs_on_i,
    output logic [1:0]       phase_o,
    output logic             sw_en_o,
    output logic [LIM_W-1:0] sink_lim_o,
    output logic             bst_refresh_o
);
    logic   active;
    phase_t phase;
    logic   sw_on;
    logic   start_pulse;
    logic   skip_pulse;

    // Run qualification from enable, supply and thermal flags
    always_comb active = en_i && vdd_ok_i && !hot_i;

    bss_phase_fsm #(.GOOD_WAIT(GOOD_WAIT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .mode_i   (mode_sel_i),
        .cross_i  (fb_cross_ss_i),
        .good_i   (fb_good_i),
        .phase_o  (phase),
        .sw_on_o  (sw_on),
        .start_o  (start_pulse)
    );

    bss_sink_ramp #(.STEP_CYC(RAMP_STEP), .LIM_W(LIM_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .sw_on_i  (sw_on),
        .lim_o    (sink_lim_o)
    );

    bss_bst_refresh #(.IDLE_MAX(REFRESH_IDLE)) u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .skip_i   (phase == PH_SKIP),
        .hs_on_i  (hs_on_i),
        .pulse_o  (skip_pulse)
    );

    // Output mapping
    always_comb begin
        phase_o       = phase;
        sw_en_o       = sw_on;
        bst_refresh_o = start_pulse || skip_pulse;
    end

    AST_START_LOW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_on && active) |=> (sw_on == bst_refresh_o) || !sw_on); // R4
endmodule

// File: tb/tb_buck_start_seq.sv
module tb_buck_start_seq;
    logic       clk = 1'b0;
    logic       rst_n, en_i, vdd_ok_i, hot_i, fb_cross_ss_i, fb_good_i, hs_on_i;
    logic [1:0] mode_sel_i;
    logic [1:0] phase_o;
    logic       sw_en_o, bst_refresh_o;
    logic [1:0] sink_lim_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    buck_start_seq dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .vdd_ok_i(vdd_ok_i), .hot_i(hot_i),
        .mode_sel_i(mode_sel_i), .fb_cross_ss_i(fb_cross_ss_i), .fb_good_i(fb_good_i),
        .hs_on_i(hs_on_i), .phase_o(phase_o), .sw_en_o(sw_en_o),
        .sink_lim_o(sink_lim_o), .bst_refresh_o(bst_refresh_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        en_i = 1'b0; fb_cross_ss_i = 1'b0; fb_good_i = 1'b0; hs_on_i = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en_i = 1'b1; vdd_ok_i = 1'b1; hot_i = 1'b0;
        mode_sel_i = 2'd0; fb_cross_ss_i = 1'b0; fb_good_i = 1'b0; hs_on_i = 1'b0;
        step(3);
        check("R1 reset phase", phase_o, 0);
        check("R1 reset sw_en", sw_en_o, 0);
        check("R1 reset lim", sink_lim_o, 0);
        check("R1 reset refresh", bst_refresh_o, 0);
        en_i = 1'b0;
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_low_mode_ramp();
        int bad;
        mode_sel_i = 2'd0; hs_on_i = 1'b0; en_i = 1'b1;
        step(1);
        check("R2 low phase FPWM", phase_o, 2);
        check("R2 low sw_en", sw_en_o, 1);
        check("R4 start refresh", bst_refresh_o, 1);
        check("R5 lim at start", sink_lim_o, 0);
        step(1);
        check("R4 refresh single", bst_refresh_o, 0);
        step(30);
        check("R5 lim before 32", sink_lim_o, 0);
        step(1);
        check("R5 lim at 32", sink_lim_o, 1);
        step(32);
        check("R5 lim at 64", sink_lim_o, 2);
        step(32);
        check("R5 lim at 96", sink_lim_o, 3);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            step(1);
            if (bst_refresh_o !== 1'b0) bad++;
            if (sink_lim_o !== 2'd3) bad++;
        end
        check("R10 R5 no refresh in FPWM, lim saturated", bad, 0);
        en_i = 1'b0;
        step(1);
        check("R1 disable phase", phase_o, 0);
        check("R1 disable lim", sink_lim_o, 0);
        check("R1 disable sw_en", sw_en_o, 0);
    endtask

    task automatic t_mid_mode();
        int bad;
        mode_sel_i = 2'd1; fb_cross_ss_i = 1'b0; fb_good_i = 1'b0; hs_on_i = 1'b0;
        en_i = 1'b1;
        step(1);
        check("R3 mid phase MONO", phase_o, 1);
        check("R3 mid sw off", sw_en_o, 0);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (sw_en_o !== 1'b0 || bst_refresh_o !== 1'b0) bad++;
        end
        check("R3 R10 hold off before cross", bad, 0);
        fb_cross_ss_i = 1'b1;
        step(1);
        check("R3 sw on after cross", sw_en_o, 1);
        check("R4 refresh at start", bst_refresh_o, 1);
        mode_sel_i = 2'd2;
        step(3);
        check("R7 mode ignored in MONO", phase_o, 1);
        mode_sel_i = 2'd1;
        fb_good_i = 1'b1;
        step(200);
        fb_good_i = 1'b0;
        step(1);
        fb_good_i = 1'b1;
        step(4095);
        check("R6 not yet at 4095", phase_o, 1);
        step(1);
        check("R6 R7 handover to FPWM", phase_o, 2);
        mode_sel_i = 2'd2;
        step(1);
        check("R8 FPWM to SKIP", phase_o, 3);
        mode_sel_i = 2'd0;
        step(1);
        check("R8 SKIP to FPWM on low", phase_o, 2);
        mode_sel_i = 2'd2;
        step(1);
        mode_sel_i = 2'd3;
        step(1);
        check("R8 open gives FPWM", phase_o, 2);
        go_idle();
        check("R1 idle after mid", phase_o, 0);
    endtask

    task automatic t_high_mode_skip();
        mode_sel_i = 2'd2; hs_on_i = 1'b1; fb_cross_ss_i = 1'b1; fb_good_i = 1'b0;
        en_i = 1'b1;
        step(1);
        check("R3 high uses MONO", phase_o, 1);
        check("R3 high sw off first edge", sw_en_o, 0);
        step(1);
        check("R3 high sw on", sw_en_o, 1);
        fb_good_i = 1'b1;
        step(4096);
        check("R7 handover to SKIP", phase_o, 3);
        step(2);
        hs_on_i = 1'b0;
        step(8);
        check("R9 no refresh at 8 idle", bst_refresh_o, 0);
        step(1);
        check("R9 refresh at 9 idle", bst_refresh_o, 1);
        step(1);
        check("R9 refresh one cycle", bst_refresh_o, 0);
        step(7);
        check("R9 no early repeat", bst_refresh_o, 0);
        step(1);
        check("R9 repeat refresh", bst_refresh_o, 1);
        hs_on_i = 1'b1;
        step(1);
        hs_on_i = 1'b0;
        step(8);
        check("R9 count reset by high side", bst_refresh_o, 0);
        step(1);
        check("R9 refresh after reset run", bst_refresh_o, 1);
        vdd_ok_i = 1'b0;
        step(1);
        check("R1 supply loss idle", phase_o, 0);
        vdd_ok_i = 1'b1;
        step(1);
        check("R3 restart in MONO", phase_o, 1);
        hot_i = 1'b1;
        step(1);
        check("R1 thermal idle", phase_o, 0);
        check("R1 thermal lim", sink_lim_o, 0);
        hot_i = 1'b0;
        go_idle();
    endtask

    task automatic t_open_mode();
        mode_sel_i = 2'd3; fb_cross_ss_i = 1'b0; en_i = 1'b1;
        step(1);
        check("R2 open treated as mid", phase_o, 1);
        check("R2 open sw off", sw_en_o, 0);
        go_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_low_mode_ramp();
        t_mid_mode();
        t_high_mode_skip();
        t_open_mode();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule